// File: doc/BRIEF.md
# Banked RAM Access Arbiter

This block sits between several DMA masters and a RAM divided into independent banks. Each master raises a request carrying a word address, a write flag and write data. The top bits of the address select a bank and the remaining bits select a word inside it. Every bank runs its own arbitration, so masters that aim at different banks in the same cycle are all served together.

When more than one master aims at one bank, the master with the lowest index wins. The others keep their requests raised and are served in later free slots. After a grant, a bank refuses new work for one cycle, which limits each bank to one transfer every two cycles. A master holds its request steady until it sees its grant pulse. A read returns its word one cycle after the grant, marked by a valid pulse to that master.

Top module: `bank_ram_arbiter`

## Requirements
- R1: An address is split as {bank, offset}. The upper log2(banks) bits select the bank and the lower log2(words per bank) bits select the word inside the bank.
- R2: A bank issues at most one grant in any cycle, and issues no grant in the cycle that follows one of its own grants.
- R3: Masters that request different free banks in the same cycle are all granted in that cycle.
- R4: When several masters request one free bank, only the requester with the lowest index is granted. The others receive no grant.
- R5: A requested bank that did not grant in the previous cycle grants to one of its requesters in the current cycle, in the same cycle the request is seen.
- R6: grant is a one-cycle pulse. It is raised only for a master whose reqValid is high.
- R7: The cycle after a read grant, rdValid pulses for that master. rdValid is never raised without a read grant in the previous cycle.
- R8: A granted write stores the master's data at its addressed word. A later read of that word returns the most recently written value.
- R9: While reset is held and in the first cycle after it with no requests, all grant and rdValid outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_MASTERS | Per-master request |
| reqWrite | input | NUM_MASTERS | Per-master write flag (1 = write) |
| reqAddr | input | NUM_MASTERS*ADDR_W | Per-master word address, master m in slice m |
| reqWdata | input | NUM_MASTERS*DATA_W | Per-master write data |
| grant | output | NUM_MASTERS | One-cycle grant pulse per master |
| rdValid | output | NUM_MASTERS | Read data valid, one cycle after a read grant |
| rdData | output | NUM_MASTERS*DATA_W | Per-master read data, valid with rdValid |

## Verification
The hardest situation to reach is a bank that is saturated while its neighbours are not. Here the per-bank busy slot, the priority ordering and the concurrent grants on other banks all interact in the same cycles. The bench drives batches in which every subset of masters piles onto one bank, with mixed reads and writes. It also drives batches in which masters spread over banks with varying strides, so that shared and private banks occur together. A bench-side model tracks which banks are busy and which masters are still pending, and predicts the exact grant vector in every cycle.

// File: rtl/mbra_pkg.sv
package mbra_pkg;
  parameter int unsigned NUM_MASTERS = 4;
  parameter int unsigned NUM_BANKS   = 8;
  localparam int unsigned MIDX_W = $clog2(NUM_MASTERS);
  localparam int unsigned BIDX_W = $clog2(NUM_BANKS);

  // Control to datapath strobes: per bank, start a transfer and for whom
  typedef struct packed {
    logic [NUM_BANKS-1:0]             fire;
    logic [NUM_BANKS-1:0][MIDX_W-1:0] owner;
  } bankStrobe_t;
endpackage

// File: rtl/bank_arb_ctrl.sv
module bank_arb_ctrl
  import mbra_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        reqValid,
  input  logic [NUM_MASTERS*ADDR_W-1:0] reqAddr,
  output logic [NUM_MASTERS-1:0]        grant,
  output bankStrobe_t                   strobe
);
  localparam int unsigned OFF_W = ADDR_W - BIDX_W;

  logic [NUM_BANKS-1:0][NUM_MASTERS-1:0] hitMap;
  logic [NUM_BANKS-1:0]                  bankFire;
  logic [NUM_BANKS-1:0][MIDX_W-1:0]      bankOwner;
  logic [NUM_BANKS-1:0]                  bankBusy;

  function automatic logic [MIDX_W-1:0] lowestSet(input logic [NUM_MASTERS-1:0] v);
    lowestSet = '0;
    for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
      if (v[i]) lowestSet = MIDX_W'(i);
    end
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
      assign hitMap[b][m] = reqValid[m] &&
        (reqAddr[m*ADDR_W+OFF_W +: BIDX_W] == BIDX_W'(b));
    end
    assign bankOwner[b] = lowestSet(hitMap[b]);
    assign bankFire[b]  = (|hitMap[b]) && !bankBusy[b];
  end

  assign strobe = '{fire: bankFire, owner: bankOwner};

  always_comb begin
    grant = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankFire[b]) grant[bankOwner[b]] = 1'b1;
    end
  end

  // A bank that fired is unavailable for exactly the next cycle
  always_ff @(posedge clk) begin
    if (!rstN) bankBusy <= '0;
    else       bankBusy <= bankFire;
  end
endmodule

// File: rtl/bank_ram_dp.sv
module bank_ram_dp
  import mbra_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BANK_WORDS = 16,
  parameter int unsigned ADDR_W     = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankStrobe_t                   strobe,
  input  logic [NUM_MASTERS-1:0]        reqWrite,
  input  logic [NUM_MASTERS*ADDR_W-1:0] reqAddr,
  input  logic [NUM_MASTERS*DATA_W-1:0] reqWdata,
  output logic [NUM_MASTERS-1:0]        rdValid,
  output logic [NUM_MASTERS*DATA_W-1:0] rdData
);
  localparam int unsigned OFF_W = $clog2(BANK_WORDS);

  logic [NUM_BANKS-1:0][DATA_W-1:0] bankRdData;
  logic [NUM_BANKS-1:0]             bankRdLive;
  logic [NUM_BANKS-1:0][MIDX_W-1:0] bankRdOwner;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] memArr [BANK_WORDS];
    logic [MIDX_W-1:0] owner;
    logic [OFF_W-1:0]  selOff;
    logic              selWr;
    logic [DATA_W-1:0] selData;
    logic [DATA_W-1:0] rdReg;
    logic              rdLive;
    logic [MIDX_W-1:0] rdOwner;

    assign owner   = strobe.owner[b];
    assign selOff  = reqAddr[int'(owner)*ADDR_W +: OFF_W];
    assign selWr   = reqWrite[owner];
    assign selData = reqWdata[int'(owner)*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
      if (strobe.fire[b] && selWr)  memArr[selOff] <= selData;
      if (strobe.fire[b] && !selWr) rdReg <= memArr[selOff];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdLive  <= 1'b0;
        rdOwner <= '0;
      end else begin
        rdLive  <= strobe.fire[b] && !selWr;
        rdOwner <= owner;
      end
    end

    assign bankRdData[b]  = rdReg;
    assign bankRdLive[b]  = rdLive;
    assign bankRdOwner[b] = rdOwner;
  end

  // A master holds at most one grant per cycle, so at most one bank returns to it
  always_comb begin
    rdValid = '0;
    rdData  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankRdLive[b]) begin
        rdValid[bankRdOwner[b]] = 1'b1;
        rdData[int'(bankRdOwner[b])*DATA_W +: DATA_W] = bankRdData[b];
      end
    end
  end
endmodule

// File: rtl/bank_ram_arbiter.sv
module bank_ram_arbiter
  import mbra_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BANK_WORDS = 16,
  parameter int unsigned ADDR_W     = BIDX_W + $clog2(BANK_WORDS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        reqValid,
  input  logic [NUM_MASTERS-1:0]        reqWrite,
  input  logic [NUM_MASTERS*ADDR_W-1:0] reqAddr,
  input  logic [NUM_MASTERS*DATA_W-1:0] reqWdata,
  output logic [NUM_MASTERS-1:0]        grant,
  output logic [NUM_MASTERS-1:0]        rdValid,
  output logic [NUM_MASTERS*DATA_W-1:0] rdData
);
  bankStrobe_t strobe;

  bank_arb_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .grant(grant), .strobe(strobe)
  );

  bank_ram_dp #(.DATA_W(DATA_W), .BANK_WORDS(BANK_WORDS), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/bank_ram_arbiter_chk.sv
module bank_ram_arbiter_chk
  import mbra_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_MASTERS-1:0]        reqValid,
  input logic [NUM_MASTERS-1:0]        reqWrite,
  input logic [NUM_MASTERS*ADDR_W-1:0] reqAddr,
  input logic [NUM_MASTERS*DATA_W-1:0] reqWdata,
  input logic [NUM_MASTERS-1:0]        grant,
  input logic [NUM_MASTERS-1:0]        rdValid,
  input logic [NUM_MASTERS*DATA_W-1:0] rdData
);
  logic [NUM_BANKS-1:0][NUM_MASTERS-1:0] grantOn;
  logic [NUM_BANKS-1:0][NUM_MASTERS-1:0] reqOn;
  logic [NUM_BANKS-1:0]                  bankGrant;
  logic [NUM_BANKS-1:0]                  prevBankGrant;
  logic [NUM_BANKS-1:0]                  prioBad;
  logic [NUM_MASTERS-1:0]                prevReadGrant;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_m
      assign reqOn[b][m] = reqValid[m] &&
        (reqAddr[m*ADDR_W+ADDR_W-1 -: BIDX_W] == BIDX_W'(b));
      assign grantOn[b][m] = grant[m] && reqOn[b][m];
    end
    assign bankGrant[b] = |grantOn[b];

    always_comb begin
      prioBad[b] = 1'b0;
      for (int m = 1; m < NUM_MASTERS; m++) begin
        for (int k = 0; k < m; k++) begin
          if (grantOn[b][m] && reqOn[b][k]) prioBad[b] = 1'b1;
        end
      end
    end

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantOn[b]));
    assert_bank_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
      bankGrant[b] |=> !bankGrant[b]);
    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
      !prioBad[b]);
    assert_no_idle_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
      ((|reqOn[b]) && !prevBankGrant[b]) |-> bankGrant[b]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBankGrant <= '0;
      prevReadGrant <= '0;
    end else begin
      prevBankGrant <= bankGrant;
      prevReadGrant <= grant & ~reqWrite;
    end
  end

  assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~reqValid) == '0);
  assert_read_return_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == prevReadGrant);
endmodule

bind bank_ram_arbiter bank_ram_arbiter_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/bank_ram_arbiter_tb_top.sv
module bank_ram_arbiter_tb_top;
  localparam int NM = 4;
  localparam int NB = 8;
  localparam int BW = 16;
  localparam int DW = 32;
  localparam int AW = 7;
  localparam int WORDS = NB * BW;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NM-1:0]     reqValid = '0;
  logic [NM-1:0]     reqWrite = '0;
  logic [NM*AW-1:0]  reqAddr = '0;
  logic [NM*DW-1:0]  reqWdata = '0;
  logic [NM-1:0]     grant;
  logic [NM-1:0]     rdValid;
  logic [NM*DW-1:0]  rdData;

  bank_ram_arbiter dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .grant(grant),
    .rdValid(rdValid), .rdData(rdData)
  );

  always #5 clk = ~clk;

  int errCount = 0;
  int chkCount = 0;
  int cycles = 0;

  logic [DW-1:0] refMem [WORDS];
  logic [NB-1:0] mBusy = '0;
  logic [AW-1:0] bAddr [NM];
  logic          bWr   [NM];
  logic [DW-1:0] bData [NM];
  logic [NM-1:0] bMask;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    chkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] dataOf(input int a, input int salt);
    return (32'h9E3779B9 * DW'(a + 1)) ^ DW'(salt * 32'h01000193);
  endfunction

  function automatic int bankOf(input logic [AW-1:0] a);
    return int'(a[AW-1 -: 3]); // R1: upper bits select the bank
  endfunction

  // One batch: predicts grants cycle by cycle from the model of busy banks
  task automatic runBatch();
    logic [NM-1:0] pend = bMask;
    logic [NM-1:0] expRd = '0;
    logic [NM-1:0] expG;
    logic [NB-1:0] newBusy;
    logic [DW-1:0] expData [NM];
    bit            taken;
    int            guard = 0;
    while (1) begin
      @(negedge clk);
      chk(rdValid == expRd, "R7 rdValid", 64'(rdValid), 64'(expRd));
      for (int m = 0; m < NM; m++) begin
        if (expRd[m])
          chk(rdData[m*DW +: DW] == expData[m], "R8 rdData", 64'(rdData[m*DW +: DW]), 64'(expData[m]));
      end
      reqValid = pend;
      for (int m = 0; m < NM; m++) begin
        reqWrite[m] = bWr[m];
        reqAddr[m*AW +: AW] = bAddr[m];
        reqWdata[m*DW +: DW] = bData[m];
      end
      #1;
      expG = '0;
      newBusy = '0;
      for (int b = 0; b < NB; b++) begin
        taken = 1'b0;
        if (!mBusy[b]) begin
          for (int m = 0; m < NM; m++) begin
            if (!taken && pend[m] && bankOf(bAddr[m]) == b) begin
              expG[m] = 1'b1;
              taken = 1'b1;
              newBusy[b] = 1'b1;
            end
          end
        end
      end
      chk(grant == expG, "R2 R3 R4 R5 R6 grant", 64'(grant), 64'(expG));
      expRd = '0;
      for (int m = 0; m < NM; m++) begin
        if (expG[m]) begin
          if (bWr[m]) refMem[int'(bAddr[m])] = bData[m];
          else begin
            expRd[m] = 1'b1;
            expData[m] = refMem[int'(bAddr[m])];
          end
        end
      end
      mBusy = newBusy;
      pend = pend & ~expG;
      guard++;
      if ((pend == '0 && expG == '0) || guard > 64) break;
    end
    chk(guard <= 64, "R5 batch progress", 64'(guard), 64'd64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(grant == '0 && rdValid == '0, "R9 reset outputs", 64'({grant, rdValid}), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(grant == '0 && rdValid == '0, "R9 idle after reset", 64'({grant, rdValid}), 64'd0);

    // R8 R1: fill every word, one master at a time
    for (int a = 0; a < WORDS; a++) begin
      for (int m = 0; m < NM; m++) begin bAddr[m] = '0; bWr[m] = 1'b0; bData[m] = '0; end
      bMask = NM'(1) << (a % NM);
      bAddr[a % NM] = AW'(a);
      bWr[a % NM] = 1'b1;
      bData[a % NM] = dataOf(a, 0);
      runBatch();
    end
    // R7 R8: read every word back with a different master
    for (int a = 0; a < WORDS; a++) begin
      bMask = NM'(1) << ((a + 1) % NM);
      bAddr[(a + 1) % NM] = AW'(a);
      bWr[(a + 1) % NM] = 1'b0;
      runBatch();
    end
    // R4 R2 R5: every subset of masters on one bank, mixed reads and writes
    for (int mask = 1; mask < (1 << NM); mask++) begin
      for (int bk = 0; bk < NB; bk++) begin
        bMask = NM'(mask);
        for (int m = 0; m < NM; m++) begin
          bAddr[m] = AW'(bk * BW + ((m * 5 + mask) % BW));
          bWr[m] = ((mask + m + bk) % 3) == 0;
          bData[m] = dataOf(mask * 64 + bk * 4 + m, 7);
        end
        runBatch();
      end
    end
    // R3 R1: masters spread over banks with varying strides
    for (int sp = 0; sp < 4; sp++) begin
      for (int s = 0; s < NB; s++) begin
        bMask = '1;
        for (int m = 0; m < NM; m++) begin
          bAddr[m] = AW'(((s + m * sp) % NB) * BW + ((s + m) % BW));
          bWr[m] = (m % 2) == (sp % 2);
          bData[m] = dataOf(sp * 100 + s * 8 + m, 3);
        end
        runBatch();
      end
    end
    // R8: final readback of a bank stripe after the mixed traffic
    for (int a = 0; a < WORDS; a += 3) begin
      bMask = 4'b0001;
      bAddr[0] = AW'(a);
      bWr[0] = 1'b0;
      runBatch();
    end
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog R5 actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end
endmodule